// File: doc/BRIEF.md
# Synchronous Burst Read Slave

This block is the target side of a synchronous host bus with separate address and data lines. It answers sequential burst reads of 16-bit words from an internal memory. The host holds chip select low, puts a start address on the bus and pulls the strobe low for one clock. After a fixed number of wait cycles, the block drives the first word and pulls its active-low ready. Every following clock it presents the word at the next address. The burst ends when the host pulls its active-low last input. On the next edge the block releases the data bus and raises ready.

The data bus is tri-state at the pad. The block gives a registered data word together with a drive enable. The block checks that both word enables stay set for the whole transfer. If they do not, the block serves no data and raises a protocol error flag. The stop output follows an external queue-full indication. A preload write port fills the memory before use.

Top module: `burst_rd_slave`

## Requirements
- R1: During and directly after reset, the outputs are: ready high (`rdy_n`=1), bus not driven (`rd_oe`=0), stop high (`stop_n`=1) and no protocol error (`prot_err`=0).
- R2: A start is accepted when the block is idle and, at a clock edge, `strb_n`=0, `sel_n`=0, `rd_wr`=1 (read) and `mem_sel`=1 (memory space). Call that edge 0. The first word appears on `rd_data` with `rd_oe`=1 after edge WAIT_CYC, and not before.
- R3: `rdy_n` is low exactly in the cycles where `rd_oe` is high.
- R4: While `last_n` is high, the word shown after edge WAIT_CYC+i is the memory word at address start+i.
- R5: When `last_n` is sampled low while a word is shown, `rd_oe` falls and `rdy_n` rises at that same edge.
- R6: If `sel_n` is sampled high during the wait or data phase, the burst aborts at that edge: `rd_oe`=0 and `rdy_n`=1.
- R7: Both word-enable bits must be set. If `wen`≠2'b11 at an accepted start, or at any edge of the wait or data phase, no data is driven from that edge on and `prot_err` goes high. `prot_err` stays high until the next accepted start.
- R8: `stop_n` equals the inverse of `fifo_full`, one edge later.
- R9: These strobes are ignored and do not disturb the running address sequence: a strobe during a burst, a strobe with `rd_wr`=0 (write), and a strobe with `mem_sel`=0.
- R10: After a burst ends, the block does not accept a new start until it has sampled `sel_n` high. A strobe in that window drives no data.
- R11: The read address wraps from 2^AW-1 to 0 within a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_n | input | 1 | Chip select, active low |
| strb_n | input | 1 | Start strobe, active low |
| addr | input | AW | Start word address |
| mem_sel | input | 1 | 1 = memory space, 0 = register space |
| rd_wr | input | 1 | 1 = read, 0 = write |
| wen | input | 2 | Word enables, must be 2'b11 |
| last_n | input | 1 | Final-word flag, active low |
| fifo_full | input | 1 | External queue full |
| pl_we | input | 1 | Preload write enable |
| pl_addr | input | AW | Preload address |
| pl_data | input | DW | Preload data |
| rd_data | output | DW | Read data to pad |
| rd_oe | output | 1 | Pad drive enable for read data |
| rdy_n | output | 1 | Data ready, active low |
| stop_n | output | 1 | Stop, active low |
| prot_err | output | 1 | Word-enable protocol error |

## Verification
Counting the accepted strobe as edge 0, the first word and ready are due after edge WAIT_CYC. Word i is due after edge WAIT_CYC+i. The release is due on the same edge that samples `last_n` low. An abort on `sel_n` or a bad word enable also takes effect on the edge that samples it. `stop_n` follows `fifo_full` after one edge. The bench drives inputs on the falling edge and samples half a cycle after each rising edge. It steps through exactly these edge counts and checks both the quiet cycles before a result and the cycle the result is due.

// File: rtl/brs_pkg.sv
package brs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_BURST = 2'd2,
    ST_DONE  = 2'd3
  } brs_state_t;
endpackage

// File: rtl/brs_mem.sv
// Simple dual-port word memory: one write port for preload, one registered
// read port, shaped so block RAM is inferred.
module brs_mem #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/brs_wait_cnt.sv
// Counts the wait phase down from WAIT_CYC-1; expired marks the last wait edge.
module brs_wait_cnt #(
  parameter int WAIT_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic dec,
  output logic expired
);
  localparam int CW = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
  localparam logic [CW-1:0] LOADV = CW'(WAIT_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (load)              cnt <= LOADV;
    else if (dec && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/brs_ctrl.sv
// Burst read controller: start qualification, wait phase, sequential fetch,
// release on last, abort on deselect or bad word enables.
module brs_ctrl
  import brs_pkg::*;
#(
  parameter int AW       = 8,
  parameter int WAIT_CYC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_n,
  input  logic          strb_n,
  input  logic [AW-1:0] addr,
  input  logic          mem_sel,
  input  logic          rd_wr,
  input  logic [1:0]    wen,
  input  logic          last_n,
  output logic          mem_re,
  output logic [AW-1:0] mem_raddr,
  output logic          rd_oe,
  output logic          rdy_n,
  output logic          prot_err
);
  brs_state_t    state;
  logic [AW-1:0] ptr;
  logic          start_req, wen_ok, wait_exp, wait_load;

  assign wen_ok    = (wen == 2'b11);
  assign start_req = (state == ST_IDLE) && !sel_n && !strb_n && rd_wr && mem_sel;
  assign wait_load = start_req && wen_ok;

  brs_wait_cnt #(.WAIT_CYC(WAIT_CYC)) i_wait (
    .clk     (clk),
    .rst     (rst),
    .load    (wait_load),
    .dec     (state == ST_WAIT),
    .expired (wait_exp)
  );

  // A word is fetched on the edge that opens the data phase and on every
  // edge that continues it.
  assign mem_re = !sel_n && wen_ok &&
                  (((state == ST_WAIT) && wait_exp) ||
                   ((state == ST_BURST) && last_n));
  assign mem_raddr = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      ptr      <= '0;
      rd_oe    <= 1'b0;
      rdy_n    <= 1'b1;
      prot_err <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start_req) begin
            if (wen_ok) begin
              ptr      <= addr;
              state    <= ST_WAIT;
              prot_err <= 1'b0;
            end else begin
              prot_err <= 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (sel_n) begin
            state <= ST_IDLE;
          end else if (!wen_ok) begin
            state    <= ST_IDLE;
            prot_err <= 1'b1;
          end else if (wait_exp) begin
            state <= ST_BURST;
            rd_oe <= 1'b1;
            rdy_n <= 1'b0;
            ptr   <= ptr + 1'b1;
          end
        end
        ST_BURST: begin
          if (sel_n || !wen_ok) begin
            state <= ST_IDLE;
            rd_oe <= 1'b0;
            rdy_n <= 1'b1;
            if (!sel_n) prot_err <= 1'b1;
          end else if (!last_n) begin
            state <= ST_DONE;
            rd_oe <= 1'b0;
            rdy_n <= 1'b1;
          end else begin
            ptr <= ptr + 1'b1;
          end
        end
        default: begin
          if (sel_n) state <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/burst_rd_slave.sv
module burst_rd_slave #(
  parameter int AW       = 8,
  parameter int DW       = 16,
  parameter int WAIT_CYC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_n,
  input  logic          strb_n,
  input  logic [AW-1:0] addr,
  input  logic          mem_sel,
  input  logic          rd_wr,
  input  logic [1:0]    wen,
  input  logic          last_n,
  input  logic          fifo_full,
  input  logic          pl_we,
  input  logic [AW-1:0] pl_addr,
  input  logic [DW-1:0] pl_data,
  output logic [DW-1:0] rd_data,
  output logic          rd_oe,
  output logic          rdy_n,
  output logic          stop_n,
  output logic          prot_err
);
  logic          mem_re;
  logic [AW-1:0] mem_raddr;

  brs_ctrl #(.AW(AW), .WAIT_CYC(WAIT_CYC)) i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .sel_n     (sel_n),
    .strb_n    (strb_n),
    .addr      (addr),
    .mem_sel   (mem_sel),
    .rd_wr     (rd_wr),
    .wen       (wen),
    .last_n    (last_n),
    .mem_re    (mem_re),
    .mem_raddr (mem_raddr),
    .rd_oe     (rd_oe),
    .rdy_n     (rdy_n),
    .prot_err  (prot_err)
  );

  brs_mem #(.AW(AW), .DW(DW)) i_mem (
    .clk   (clk),
    .we    (pl_we),
    .waddr (pl_addr),
    .wdata (pl_data),
    .re    (mem_re),
    .raddr (mem_raddr),
    .rdata (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) stop_n <= 1'b1;
    else     stop_n <= ~fifo_full;
  end
endmodule

// File: rtl/burst_rd_slave_chk.sv
module burst_rd_slave_chk (
  input logic       clk,
  input logic       rst,
  input logic       sel_n,
  input logic [1:0] wen,
  input logic       last_n,
  input logic       fifo_full,
  input logic       rd_oe,
  input logic       rdy_n,
  input logic       stop_n,
  input logic       prot_err
);
  a_r3_ready_tracks_drive: assert property (@(posedge clk) disable iff (rst)
    rdy_n == !rd_oe);

  a_r5_release_on_last: assert property (@(posedge clk) disable iff (rst)
    (rd_oe && !last_n) |=> (!rd_oe && rdy_n));

  a_r4_burst_continues: assert property (@(posedge clk) disable iff (rst)
    (rd_oe && last_n && !sel_n && wen == 2'b11) |=> (rd_oe && !rdy_n));

  a_r6_deselect_aborts: assert property (@(posedge clk) disable iff (rst)
    sel_n |=> (!rd_oe && rdy_n));

  a_r7_error_blocks_data: assert property (@(posedge clk) disable iff (rst)
    prot_err |-> !rd_oe);

  a_r8_stop_follows_full: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (stop_n == !$past(fifo_full)));
endmodule

bind burst_rd_slave burst_rd_slave_chk i_chk (.*);

// File: tb/test_burst_rd_slave.sv
module test_burst_rd_slave;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int WAIT_CYC = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sel_n = 1'b1, strb_n = 1'b1, mem_sel = 1'b1, rd_wr = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [1:0]    wen = 2'b11;
  logic          last_n = 1'b1, fifo_full = 1'b0;
  logic          pl_we = 1'b0;
  logic [AW-1:0] pl_addr = '0;
  logic [DW-1:0] pl_data = '0;
  logic [DW-1:0] rd_data;
  logic          rd_oe, rdy_n, stop_n, prot_err;

  int nchk = 0;
  int nfail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  burst_rd_slave #(.AW(AW), .DW(DW), .WAIT_CYC(WAIT_CYC)) i_burst_rd_slave (
    .clk(clk), .rst(rst), .sel_n(sel_n), .strb_n(strb_n), .addr(addr),
    .mem_sel(mem_sel), .rd_wr(rd_wr), .wen(wen), .last_n(last_n),
    .fifo_full(fifo_full), .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data),
    .rd_data(rd_data), .rd_oe(rd_oe), .rdy_n(rdy_n), .stop_n(stop_n),
    .prot_err(prot_err)
  );

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return (DW'(a) * 16'h9E37) ^ 16'hA5C3;
  endfunction

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic quiet(input string req, input int n);
    for (int k = 0; k < n; k++) begin
      step;
      chk(req, {31'd0, rd_oe}, 32'd0);
    end
  endtask

  // Full burst of n words from a; inj >= 0 injects a stray strobe at that word;
  // keep_sel holds select low after the end to probe the done window (R10).
  task automatic run_burst(input logic [AW-1:0] a, input int n, input int inj, input bit keep_sel);
    sel_n = 1'b0; strb_n = 1'b0; addr = a; rd_wr = 1'b1; mem_sel = 1'b1;
    wen = 2'b11; last_n = 1'b1;
    step;                                   // edge 0
    strb_n = 1'b1;
    chk("R2 no data at strobe edge", {31'd0, rd_oe}, 32'd0);
    chk("R7 error cleared by accepted start", {31'd0, prot_err}, 32'd0);
    for (int k = 1; k < WAIT_CYC; k++) begin
      step;
      chk("R2 no data during wait", {31'd0, rd_oe}, 32'd0);
    end
    step;                                   // edge WAIT_CYC
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] ai;
      ai = a + AW'(i);
      strb_n = 1'b1;
      chk("R2 R3 driving with ready low", {30'd0, rd_oe, rdy_n}, 32'd2);
      chk("R4 R11 sequential word", {16'd0, rd_data}, {16'd0, pat(ai)});
      if (i == inj) begin
        strb_n = 1'b0;                      // R9 stray strobe mid-burst
        addr = ~a;
      end
      if (i == n - 1) last_n = 1'b0;
      step;
    end
    strb_n = 1'b1;
    chk("R5 released on last edge", {30'd0, rd_oe, rdy_n}, 32'd1);
    last_n = 1'b1;
    if (keep_sel) begin
      strb_n = 1'b0; addr = a;
      step;
      strb_n = 1'b1;
      chk("R10 start ignored before deselect", {31'd0, rd_oe}, 32'd0);
      quiet("R10 no data before deselect", WAIT_CYC + 2);
    end
    sel_n = 1'b1;
    step;
  endtask

  task automatic t_reset;
    chk("R1 ready high", {31'd0, rdy_n}, 32'd1);
    chk("R1 bus released", {31'd0, rd_oe}, 32'd0);
    chk("R1 stop high", {31'd0, stop_n}, 32'd1);
    chk("R1 no error", {31'd0, prot_err}, 32'd0);
  endtask

  task automatic t_abort;
    sel_n = 1'b0; strb_n = 1'b0; addr = 8'h30; wen = 2'b11; last_n = 1'b1;
    step;
    strb_n = 1'b1;
    repeat (WAIT_CYC + 1) step;             // two words shown
    chk("R6 second word before abort", {16'd0, rd_data}, {16'd0, pat(8'h31)});
    sel_n = 1'b1;
    step;
    chk("R6 aborted on deselect", {30'd0, rd_oe, rdy_n}, 32'd1);
    quiet("R6 stays idle", 2);
  endtask

  task automatic t_bad_wen_start;
    sel_n = 1'b0; strb_n = 1'b0; addr = 8'h50; wen = 2'b01;
    step;
    strb_n = 1'b1;
    chk("R7 error at bad start", {31'd0, prot_err}, 32'd1);
    quiet("R7 no data after bad start", WAIT_CYC + 2);
    wen = 2'b11; sel_n = 1'b1;
    step;
    chk("R7 error held until next start", {31'd0, prot_err}, 32'd1);
  endtask

  task automatic t_bad_wen_mid;
    sel_n = 1'b0; strb_n = 1'b0; addr = 8'h60; wen = 2'b11;
    step;
    strb_n = 1'b1;
    repeat (WAIT_CYC) step;
    chk("R7 first word before wen drop", {31'd0, rd_oe}, 32'd1);
    wen = 2'b10;
    step;
    chk("R7 data stopped on wen drop", {30'd0, rd_oe, prot_err}, 32'd1);
    wen = 2'b11; sel_n = 1'b1;
    step;
  endtask

  task automatic t_ignored_starts;
    sel_n = 1'b0; strb_n = 1'b0; rd_wr = 1'b0; addr = 8'h70;
    step;
    strb_n = 1'b1;
    quiet("R9 write strobe ignored", WAIT_CYC + 2);
    rd_wr = 1'b1; mem_sel = 1'b0; strb_n = 1'b0;
    step;
    strb_n = 1'b1;
    quiet("R9 register-space strobe ignored", WAIT_CYC + 2);
    mem_sel = 1'b1; sel_n = 1'b1;
    step;
  endtask

  task automatic t_stop;
    fifo_full = 1'b1;
    chk("R8 stop not yet low", {31'd0, stop_n}, 32'd1);
    step;
    chk("R8 stop low one edge after full", {31'd0, stop_n}, 32'd0);
    fifo_full = 1'b0;
    step;
    chk("R8 stop high after full clears", {31'd0, stop_n}, 32'd1);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step;
    t_reset;
    rst = 1'b0;
    step;
    t_reset;
    for (int i = 0; i < (1 << AW); i++) begin
      pl_we = 1'b1; pl_addr = AW'(i); pl_data = pat(AW'(i));
      step;
    end
    pl_we = 1'b0;
    run_burst(8'h10, 1, -1, 1'b0);
    run_burst(8'h20, 5, -1, 1'b0);
    run_burst(8'hFE, 4, -1, 1'b0);          // R11 wrap
    t_abort;
    t_bad_wen_start;
    run_burst(8'h11, 2, -1, 1'b0);          // clears R7 error
    t_bad_wen_mid;
    t_ignored_starts;
    run_burst(8'h40, 6, 2, 1'b0);           // R9 stray strobe
    run_burst(8'h90, 3, -1, 1'b1);          // R10 done window
    run_burst(8'hA0, 2, -1, 1'b0);
    t_stop;
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule